// File: doc/BRIEF.md
# Grouped Supply Voltage Alarm Unit

This block watches a stream of supply-voltage samples, each tagged with a channel index. It checks every sample against a lower and an upper threshold that belong to that channel. When a sample falls outside its window and the channel's alarm is enabled, the block sets a sticky flag for that channel. The alarm carries no direction: a sample above the window and a sample below it set the same flag.

Channels are packed into groups of 32. Each group has one enable word, one flag word and one interrupt request line. A request stays high while any channel in its group is both flagged and enabled. Software clears flags by writing back, as ones, the flag bits it has read.

A sample word holds a 16-bit mantissa in bits 15:0, a format flag in bit 16 and a mode field in bits 18:17. The format flag selects signed or unsigned comparison. The thresholds of a channel are taken in the same format as its samples.

Top module: `supply_alarm_unit`

## Requirements
- R1: After reset, every enable and flag word reads 0 and every request is low. Every lower threshold reads 0x0000 and every upper threshold reads 0xFFFF.
- R2: Channel index i belongs to group i/32, at bit i mod 32. Register address bits [9:8] select the region: 2 for enable words and 3 for flag words, with the group number in bits [7:0]. Channel 159 maps to group 4, bit 31.
- R3: When sample bit 16 is 0, bits 15:0 are compared unsigned. The channel alarms when the value is strictly above its upper threshold or strictly below its lower threshold. A value equal to either threshold does not alarm.
- R4: When sample bit 16 is 1, the mantissa and both thresholds are compared as two's-complement numbers, under the same strict rule.
- R5: An out-of-window sample on a channel whose enable bit is 0 leaves that channel's flag at 0.
- R6: A flag stays set after later in-window samples. A write to a flag word clears exactly the bits written as 1. Bits written as 0 are unchanged.
- R7: When a clearing write and a new alarm reach the same flag bit in the same cycle, the new alarm wins and the bit ends up set.
- R8: Request g is high exactly when some channel in group g has both its flag and its enable set. Clearing an enable bit drops the request and keeps the flag.
- R9: A sample whose channel index is 160 or more changes no flag.
- R10: A sample is judged with the thresholds and enables in force before any register write in the same cycle.
- R11: Threshold registers sit at region 0 (lower) and region 1 (upper), with the channel in address bits [7:0]. Each stores bits 15:0 of the write data and reads back zero-extended to 32 bits.
- R12: The mode field in sample bits 18:17 has no effect on the comparison.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| smp_valid | input | 1 | A sample is present this cycle |
| smp_chan | input | 8 | Channel index of the sample |
| smp_word | input | 19 | Sample word: mode[18:17], format[16], mantissa[15:0] |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 10 | Region in [9:8], channel or group in [7:0] |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Combinational read data for reg_addr |
| irq_o | output | 5 | One interrupt request per channel group |

## Verification
The bench probes both window edges in each format. A strict/inclusive mix-up would raise alarms at values equal to a threshold. A signed/unsigned swap would flag negative mantissas that lie inside a negative window. It drives a clearing write and a fresh alarm on the same group in the same cycle; a design that lets the clear win would lose the new alarm. It also writes thresholds and enables in the same cycle as a sample on that channel; a design that forwards the new values would judge the sample against the wrong window. Indices past the last channel, the top channel of the last group, and a request that must fall while its flag stays set are each checked against a behavioural model on every clock.

// File: rtl/supply_alarm_pkg.sv
package supply_alarm_pkg;
   localparam int REGION_W = 2;

   typedef enum logic [REGION_W-1:0] {
      RGN_LOWER  = 2'd0,
      RGN_UPPER  = 2'd1,
      RGN_ENABLE = 2'd2,
      RGN_FLAG   = 2'd3
   } region_e;
endpackage

// File: rtl/sa_thr_bank.sv
// Per-channel lower/upper threshold storage with one write port and two read ports
module sa_thr_bank #(
   parameter int NUM_CH = 160,
   parameter int MANT_W = 16,
   parameter int IDX_W  = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_lo,
   input  logic              wr_up,
   input  logic [IDX_W-1:0]  wr_idx,
   input  logic [MANT_W-1:0] wr_val,
   input  logic [IDX_W-1:0]  a_idx,
   output logic [MANT_W-1:0] a_lo,
   output logic [MANT_W-1:0] a_up,
   input  logic [IDX_W-1:0]  b_idx,
   output logic [MANT_W-1:0] b_lo,
   output logic [MANT_W-1:0] b_up
);
   localparam logic [IDX_W:0] CH_LIMIT = (IDX_W+1)'(NUM_CH);

   logic [MANT_W-1:0] lo_q [NUM_CH];
   logic [MANT_W-1:0] up_q [NUM_CH];
   logic wr_ok, a_ok, b_ok;

   assign wr_ok = ({1'b0, wr_idx} < CH_LIMIT);
   assign a_ok  = ({1'b0, a_idx} < CH_LIMIT);
   assign b_ok  = ({1'b0, b_idx} < CH_LIMIT);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int ch = 0; ch < NUM_CH; ch++) begin
            lo_q[ch] <= '0;
            up_q[ch] <= '1;
         end
      end else if (wr_ok) begin
         if (wr_lo) lo_q[wr_idx] <= wr_val;
         if (wr_up) up_q[wr_idx] <= wr_val;
      end
   end

   always_comb begin
      a_lo = '0;
      a_up = '1;
      b_lo = '0;
      b_up = '0;
      if (a_ok) begin
         a_lo = lo_q[a_idx];
         a_up = up_q[a_idx];
      end
      if (b_ok) begin
         b_lo = lo_q[b_idx];
         b_up = up_q[b_idx];
      end
   end
endmodule

// File: rtl/sa_window_cmp.sv
// Strict window test, signed or unsigned per sample
module sa_window_cmp #(
   parameter int MANT_W = 16
) (
   input  logic [MANT_W-1:0] val,
   input  logic [MANT_W-1:0] lo,
   input  logic [MANT_W-1:0] up,
   input  logic              is_signed,
   output logic              outside
);
   logic above_s, below_s, above_u, below_u;

   always_comb begin
      above_s = $signed(val) > $signed(up);
      below_s = $signed(val) < $signed(lo);
      above_u = val > up;
      below_u = val < lo;
      outside = is_signed ? (above_s | below_s) : (above_u | below_u);
   end
endmodule

// File: rtl/sa_group.sv
// One group of enable bits, sticky flags and its request line
module sa_group #(
   parameter int GRP_W = 32,
   parameter int LIVE  = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             en_we,
   input  logic             clr_we,
   input  logic [GRP_W-1:0] wdata,
   input  logic [GRP_W-1:0] hit,
   output logic [GRP_W-1:0] en_q,
   output logic [GRP_W-1:0] fl_q,
   output logic             irq
);
   generate
      for (genvar lane = 0; lane < GRP_W; lane++) begin : g_lane
         if (lane < LIVE) begin : g_live
            logic en_b, fl_b;
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) begin
                  en_b <= 1'b0;
                  fl_b <= 1'b0;
               end else begin
                  if (en_we) en_b <= wdata[lane];
                  // the old enable gates the set; a set outranks a clear
                  fl_b <= (fl_b & ~(clr_we & wdata[lane])) | (hit[lane] & en_b);
               end
            end
            assign en_q[lane] = en_b;
            assign fl_q[lane] = fl_b;
         end else begin : g_pad
            assign en_q[lane] = 1'b0;
            assign fl_q[lane] = 1'b0;
         end
      end
   endgenerate

   assign irq = |(en_q & fl_q);
endmodule

// File: rtl/supply_alarm_unit.sv
module supply_alarm_unit
   import supply_alarm_pkg::*;
#(
   parameter int NUM_CH = 160,
   parameter int GRP_W  = 32,
   parameter int MANT_W = 16,
   parameter int MODE_W = 2,
   parameter int IDX_W  = 8,
   localparam int NUM_GRP = (NUM_CH + GRP_W - 1) / GRP_W,
   localparam int SMP_W   = MANT_W + 1 + MODE_W,
   localparam int ADDR_W  = REGION_W + IDX_W
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               smp_valid,
   input  logic [IDX_W-1:0]   smp_chan,
   input  logic [SMP_W-1:0]   smp_word,
   input  logic               reg_we,
   input  logic [ADDR_W-1:0]  reg_addr,
   input  logic [GRP_W-1:0]   reg_wdata,
   output logic [GRP_W-1:0]   reg_rdata,
   output logic [NUM_GRP-1:0] irq_o
);
   localparam int BIT_W = $clog2(GRP_W);
   localparam int PAD_W = NUM_GRP * GRP_W;
   localparam logic [IDX_W:0] CH_LIMIT  = (IDX_W+1)'(NUM_CH);
   localparam logic [IDX_W:0] GRP_LIMIT = (IDX_W+1)'(NUM_GRP);

   if (GRP_W < MANT_W) begin : g_chk_data
      $error("GRP_W must hold a threshold");
   end
   if ((1 << BIT_W) != GRP_W) begin : g_chk_pow2
      $error("GRP_W must be a power of two");
   end
   if (NUM_CH > (1 << IDX_W)) begin : g_chk_idx
      $error("IDX_W too narrow for NUM_CH");
   end
   if (IDX_W <= BIT_W) begin : g_chk_grp
      $error("IDX_W must exceed the bit-in-group width");
   end

   region_e            rgn;
   logic [IDX_W-1:0]   rsel;
   logic               rsel_grp_ok;
   logic [IDX_W-BIT_W-1:0] smp_grp;
   logic [BIT_W-1:0]   smp_bit;
   logic               smp_live, smp_out;
   logic [MANT_W-1:0]  a_lo, a_up, b_lo, b_up;
   logic [GRP_W-1:0]   en_grp [NUM_GRP];
   logic [GRP_W-1:0]   fl_grp [NUM_GRP];
   logic [PAD_W-1:0]   en_all, flag_all;

   assign rgn         = region_e'(reg_addr[ADDR_W-1 -: REGION_W]);
   assign rsel        = reg_addr[IDX_W-1:0];
   assign rsel_grp_ok = ({1'b0, rsel} < GRP_LIMIT);
   assign smp_grp     = smp_chan[IDX_W-1:BIT_W];
   assign smp_bit     = smp_chan[BIT_W-1:0];
   assign smp_live    = smp_valid && ({1'b0, smp_chan} < CH_LIMIT);

   sa_thr_bank #(.NUM_CH(NUM_CH), .MANT_W(MANT_W), .IDX_W(IDX_W)) u_thr (
      .clk    (clk),
      .rst_n  (rst_n),
      .wr_lo  (reg_we && rgn == RGN_LOWER),
      .wr_up  (reg_we && rgn == RGN_UPPER),
      .wr_idx (rsel),
      .wr_val (reg_wdata[MANT_W-1:0]),
      .a_idx  (smp_chan),
      .a_lo   (a_lo),
      .a_up   (a_up),
      .b_idx  (rsel),
      .b_lo   (b_lo),
      .b_up   (b_up)
   );

   sa_window_cmp #(.MANT_W(MANT_W)) u_cmp (
      .val       (smp_word[MANT_W-1:0]),
      .lo        (a_lo),
      .up        (a_up),
      .is_signed (smp_word[MANT_W]),
      .outside   (smp_out)
   );

   generate
      for (genvar g = 0; g < NUM_GRP; g++) begin : g_grp
         localparam int REM  = NUM_CH - g * GRP_W;
         localparam int LIVE = (REM >= GRP_W) ? GRP_W : REM;
         logic [GRP_W-1:0] hit;
         logic sel;

         assign sel = (reg_we && rsel == IDX_W'(g));
         assign hit = (smp_live && smp_out && smp_grp == (IDX_W-BIT_W)'(g))
                      ? (GRP_W'(1) << smp_bit) : '0;

         sa_group #(.GRP_W(GRP_W), .LIVE(LIVE)) u_grp (
            .clk    (clk),
            .rst_n  (rst_n),
            .en_we  (sel && rgn == RGN_ENABLE),
            .clr_we (sel && rgn == RGN_FLAG),
            .wdata  (reg_wdata),
            .hit    (hit),
            .en_q   (en_grp[g]),
            .fl_q   (fl_grp[g]),
            .irq    (irq_o[g])
         );

         assign en_all[g*GRP_W +: GRP_W]   = en_grp[g];
         assign flag_all[g*GRP_W +: GRP_W] = fl_grp[g];
      end
   endgenerate

   always_comb begin
      reg_rdata = '0;
      unique case (rgn)
         RGN_LOWER:  reg_rdata = GRP_W'(b_lo);
         RGN_UPPER:  reg_rdata = GRP_W'(b_up);
         RGN_ENABLE: if (rsel_grp_ok) reg_rdata = en_grp[rsel];
         RGN_FLAG:   if (rsel_grp_ok) reg_rdata = fl_grp[rsel];
         default:    reg_rdata = '0;
      endcase
   end
endmodule

// File: rtl/supply_alarm_unit_chk.sv
module supply_alarm_unit_chk #(
   parameter int NUM_CH  = 160,
   parameter int NUM_GRP = 5,
   parameter int PAD_W   = 160,
   parameter int IDX_W   = 8,
   parameter int ADDR_W  = 10
) (
   input logic               clk,
   input logic               rst_n,
   input logic               smp_valid,
   input logic [IDX_W-1:0]   smp_chan,
   input logic               reg_we,
   input logic [ADDR_W-1:0]  reg_addr,
   input logic [PAD_W-1:0]   en_all,
   input logic [PAD_W-1:0]   flag_all,
   input logic [NUM_GRP-1:0] irq_o
);
   localparam logic [IDX_W:0] CH_LIMIT = (IDX_W+1)'(NUM_CH);

   // R1
   reset_quiet_chk: assert property (@(posedge clk) !rst_n |-> irq_o == '0);

   // R5
   disabled_no_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (smp_valid && ({1'b0, smp_chan} < CH_LIMIT) && !en_all[smp_chan] && !reg_we)
      |=> $stable(flag_all));

   // R9
   oob_chan_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (smp_valid && ({1'b0, smp_chan} >= CH_LIMIT) && !reg_we) |=> $stable(flag_all));

   // R6
   flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(reg_we && reg_addr[ADDR_W-1 -: 2] == 2'd3)
      |=> ((flag_all & $past(flag_all)) == $past(flag_all)));

   // R8
   irq_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((en_all & flag_all) == '0) |-> (irq_o == '0));

   // R8
   irq_active_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((en_all & flag_all) != '0) |-> (irq_o != '0));
endmodule

bind supply_alarm_unit supply_alarm_unit_chk #(
   .NUM_CH(NUM_CH), .NUM_GRP(NUM_GRP), .PAD_W(PAD_W), .IDX_W(IDX_W), .ADDR_W(ADDR_W)
) u_chk (
   .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .smp_chan(smp_chan),
   .reg_we(reg_we), .reg_addr(reg_addr), .en_all(en_all), .flag_all(flag_all),
   .irq_o(irq_o)
);

// File: tb/sim_supply_alarm_unit.sv
`timescale 1ns/1ps
module sim_supply_alarm_unit;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        smp_valid = 1'b0;
   logic [7:0]  smp_chan = '0;
   logic [18:0] smp_word = '0;
   logic        reg_we = 1'b0;
   logic [9:0]  reg_addr = '0;
   logic [31:0] reg_wdata = '0;
   logic [31:0] reg_rdata;
   logic [4:0]  irq_o;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   always #4 clk = ~clk;

   supply_alarm_unit u0 (
      .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .smp_chan(smp_chan),
      .smp_word(smp_word), .reg_we(reg_we), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq_o(irq_o)
   );

   // behavioural reference model
   logic [15:0] m_lo [160];
   logic [15:0] m_up [160];
   logic [31:0] m_en [5];
   logic [31:0] m_fl [5];

   initial begin
      for (int i = 0; i < 160; i++) begin m_lo[i] = 16'h0000; m_up[i] = 16'hFFFF; end
      for (int i = 0; i < 5; i++) begin m_en[i] = '0; m_fl[i] = '0; end
   end

   always @(posedge clk) begin : model
      int c;
      int a;
      logic hit;
      logic [15:0] v;
      if (!rst_n) begin
         for (int i = 0; i < 160; i++) begin m_lo[i] = 16'h0000; m_up[i] = 16'hFFFF; end
         for (int i = 0; i < 5; i++) begin m_en[i] = '0; m_fl[i] = '0; end
      end else begin
         hit = 1'b0;
         c = int'(smp_chan);
         v = smp_word[15:0];
         if (smp_valid && c < 160) begin
            if (smp_word[16])
               hit = ($signed(v) > $signed(m_up[c])) || ($signed(v) < $signed(m_lo[c]));
            else
               hit = (v > m_up[c]) || (v < m_lo[c]);
            hit = hit && m_en[c/32][c%32];
         end
         if (reg_we) begin
            a = int'(reg_addr[7:0]);
            case (reg_addr[9:8])
               2'd0: if (a < 160) m_lo[a] = reg_wdata[15:0];
               2'd1: if (a < 160) m_up[a] = reg_wdata[15:0];
               2'd2: if (a < 5) m_en[a] = reg_wdata;
               default: if (a < 5) m_fl[a] = m_fl[a] & ~reg_wdata;
            endcase
         end
         if (hit) m_fl[c/32][c%32] = 1'b1;
      end
   end

   function automatic logic [4:0] model_irq();
      logic [4:0] r;
      for (int g = 0; g < 5; g++) r[g] = |(m_fl[g] & m_en[g]);
      return r;
   endfunction

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
      end
   endtask

   // request lines compared with the model on every cycle
   always @(negedge clk) begin
      if (rst_n && !done) chk("R8 irq vs model", 32'(irq_o), 32'(model_irq()));
   end

   function automatic logic [9:0] ad(input logic [1:0] r, input int i);
      return {r, 8'(i)};
   endfunction

   task automatic step();
      @(posedge clk);
      @(negedge clk);
   endtask

   task automatic wr(input logic [9:0] a, input logic [31:0] d);
      reg_we = 1'b1; reg_addr = a; reg_wdata = d;
      step();
      reg_we = 1'b0; reg_wdata = '0;
   endtask

   task automatic smp(input logic [7:0] c, input logic [18:0] w);
      smp_valid = 1'b1; smp_chan = c; smp_word = w;
      step();
      smp_valid = 1'b0;
   endtask

   task automatic both(input logic [7:0] c, input logic [18:0] w,
                       input logic [9:0] a, input logic [31:0] d);
      smp_valid = 1'b1; smp_chan = c; smp_word = w;
      reg_we = 1'b1; reg_addr = a; reg_wdata = d;
      step();
      smp_valid = 1'b0; reg_we = 1'b0; reg_wdata = '0;
   endtask

   task automatic rd(input logic [9:0] a, input logic [31:0] exp, input string tag);
      reg_addr = a;
      #1;
      chk(tag, reg_rdata, exp);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         fails++;
         checks++;
         $display("FAIL watchdog expired actual=running expected=finished");
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      chk("R1 irq in reset", 32'(irq_o), 32'h0);
      rst_n = 1'b1;
      step();
      // R1 reset contents
      rd(ad(0, 5), 32'h0, "R1 lower reset");
      rd(ad(1, 5), 32'h0000FFFF, "R1 upper reset");
      rd(ad(2, 0), 32'h0, "R1 enable reset");
      rd(ad(3, 4), 32'h0, "R1 flag reset");
      chk("R1 irq after reset", 32'(irq_o), 32'h0);

      // R11 threshold storage
      wr(ad(0, 37), 32'hABCD0100);
      wr(ad(1, 37), 32'h00000200);
      rd(ad(0, 37), 32'h00000100, "R11 lower readback");
      rd(ad(1, 37), 32'h00000200, "R11 upper readback");

      // R5 disabled channel
      smp(8'd37, 19'h00300);
      rd(ad(3, 1), 32'h0, "R5 disabled flag");

      // R2 mapping: ch37 -> group 1 bit 5
      wr(ad(2, 1), 32'h20);
      smp(8'd37, 19'h00300);
      rd(ad(3, 1), 32'h20, "R2 ch37 flag");
      chk("R2 irq group1", 32'(irq_o), 32'h02);

      // R3 unsigned boundaries on ch38 (group 1 bit 6)
      wr(ad(0, 38), 32'h100);
      wr(ad(1, 38), 32'h200);
      wr(ad(2, 1), 32'h60);
      wr(ad(3, 1), 32'h20);
      rd(ad(3, 1), 32'h0, "R6 w1c clear");
      smp(8'd38, 19'h00100);
      smp(8'd38, 19'h00200);
      rd(ad(3, 1), 32'h0, "R3 equal thresholds");
      smp(8'd38, 19'h000FF);
      rd(ad(3, 1), 32'h40, "R3 below lower");
      wr(ad(3, 1), 32'h40);
      smp(8'd38, 19'h00201);
      rd(ad(3, 1), 32'h40, "R3 above upper");

      // R6 stickiness and selective clear
      smp(8'd38, 19'h00150);
      rd(ad(3, 1), 32'h40, "R6 sticky");
      wr(ad(3, 1), 32'h0);
      rd(ad(3, 1), 32'h40, "R6 zero write");
      wr(ad(3, 1), 32'hFFFFFFBF);
      rd(ad(3, 1), 32'h40, "R6 other bits");
      wr(ad(3, 1), 32'h40);
      rd(ad(3, 1), 32'h0, "R6 cleared");

      // R4 signed window on ch0: lower -256, upper 16
      wr(ad(0, 0), 32'hFF00);
      wr(ad(1, 0), 32'h0010);
      wr(ad(2, 0), 32'h1);
      smp(8'd0, 19'h1FFF0);
      rd(ad(3, 0), 32'h0, "R4 -16 inside");
      smp(8'd0, 19'h0FFF0);
      rd(ad(3, 0), 32'h1, "R3 unsigned FFF0 above");
      wr(ad(3, 0), 32'h1);
      smp(8'd0, 19'h10011);
      rd(ad(3, 0), 32'h1, "R4 17 above");
      wr(ad(3, 0), 32'h1);
      smp(8'd0, 19'h1FEFF);
      rd(ad(3, 0), 32'h1, "R4 -257 below");
      wr(ad(3, 0), 32'h1);
      smp(8'd0, 19'h1FF00);
      smp(8'd0, 19'h10010);
      rd(ad(3, 0), 32'h0, "R4 signed boundaries");

      // R12 mode field ignored
      smp(8'd0, 19'h7FFF0);
      rd(ad(3, 0), 32'h0, "R12 mode set signed inside");
      smp(8'd0, 19'h40005);
      rd(ad(3, 0), 32'h1, "R12 mode set unsigned below");
      wr(ad(3, 0), 32'h1);

      // R7 set beats clear in the same cycle
      smp(8'd38, 19'h000FF);
      rd(ad(3, 1), 32'h40, "R7 setup");
      both(8'd37, 19'h00300, ad(3, 1), 32'h60);
      rd(ad(3, 1), 32'h20, "R7 set wins");
      chk("R7 irq", 32'(irq_o), 32'h02);

      // R8 enable gates the request, flag kept
      wr(ad(2, 1), 32'h40);
      chk("R8 irq drops", 32'(irq_o), 32'h0);
      rd(ad(3, 1), 32'h20, "R8 flag kept");
      wr(ad(2, 1), 32'h60);
      chk("R8 irq returns", 32'(irq_o), 32'h02);
      wr(ad(3, 1), 32'h20);
      chk("R8 irq after clear", 32'(irq_o), 32'h0);

      // R9 out-of-range indices, R2 last channel
      wr(ad(2, 4), 32'hFFFFFFFF);
      smp(8'd160, 19'h10000);
      smp(8'd255, 19'h10000);
      rd(ad(3, 4), 32'h0, "R9 index beyond range");
      chk("R9 irq", 32'(irq_o), 32'h0);
      smp(8'd159, 19'h10000);
      rd(ad(3, 4), 32'h80000000, "R2 ch159 group4 bit31");
      chk("R2 irq group4", 32'(irq_o), 32'h10);
      wr(ad(3, 4), 32'h80000000);

      // R10 sample sees values before same-cycle writes
      wr(ad(2, 1), 32'h160);
      both(8'd40, 19'h00500, ad(1, 40), 32'h400);
      rd(ad(3, 1), 32'h0, "R10 old upper used");
      smp(8'd40, 19'h00500);
      rd(ad(3, 1), 32'h100, "R10 new upper used");
      wr(ad(3, 1), 32'h100);
      wr(ad(1, 41), 32'h10);
      both(8'd41, 19'h00500, ad(2, 1), 32'h360);
      rd(ad(3, 1), 32'h0, "R10 old enable used");
      smp(8'd41, 19'h00500);
      rd(ad(3, 1), 32'h200, "R10 new enable used");
      wr(ad(3, 1), 32'h200);
      step();

      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end
endmodule